// File: doc/BRIEF.md
# Prioritised Transmit Buffer Scheduler

This block keeps the status of a small, parameterised set of transmit message buffers and decides which one goes out next. Software-side logic drives a command strobe with a one-hot buffer select and three operation bits (abort, mark ready, mark empty). Each buffer runs its own guarded state machine, and the resulting status nibbles are packed into one status word.

A priority picker looks at every ready buffer and compares the 3-bit priorities held in a priority word. It hands the winner to a downstream transmit engine through a request/done handshake. When the engine reports completion, the buffer becomes transmitted-OK, a frame counter steps, and two one-cycle event pulses are raised (frame sent, buffer state changed). Selection then runs again, so several ready buffers drain one after another in priority order. The block also drives idle/transmitting status bits and a not-full flag that shows at least one buffer is free.

Top module: `txbuf_sched`

## Requirements
- R1: After reset every buffer is empty, `idle` is 1, `tx_busy`, `tx_req`, `evt_txdone` and `evt_bufchg` are 0, `frame_cnt` is 0 and `txnf` is 1.
- R2: Buffer i reports its state in `state_word[4i+3:4i]` with the codes empty=0, ready=1, transmitted-OK=2, failed=3, aborted=4.
- R3: The abort operation moves a selected buffer from ready to aborted and leaves it unchanged in every other state.
- R4: The mark-ready operation moves a selected buffer to ready only from empty, transmitted-OK, failed or aborted.
- R5: The mark-empty operation moves a selected buffer to empty only from transmitted-OK, failed or aborted; a ready buffer stays ready.
- R6: When one command carries several operation bits, they act on each buffer in the order abort, then mark-ready, then mark-empty, each seeing the result of the one before.
- R7: A command acts only on buffers whose bit in `cmd_sel` is 1, and is ignored entirely while `ctrl_en` is 0.
- R8: The priority of buffer i is `prio_word[4i+2:4i]`. Among ready buffers the highest priority wins, ties go to the lowest index, a priority-0 buffer is never chosen, and no transmission starts while `ctrl_en` is 0.
- R9: Once a ready buffer is chosen at a clock edge, `tx_req` is 1 with `tx_idx` naming it from that edge until the edge where `tx_done` is sampled. Commands addressed to that buffer are ignored during this time.
- R10: At the edge where `tx_done` is sampled with `tx_req` high, the sent buffer becomes transmitted-OK, `frame_cnt` increments by one, and `tx_req` drops. `evt_txdone` and `evt_bufchg` are both 1 for exactly the following cycle. The next ready buffer is picked at the edge after that.
- R11: `tx_busy` is 1 and `idle` is 0 exactly while `tx_req` is 1.
- R12: `txnf` is 1 whenever at least one buffer is empty and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable; gates commands and transmission starts |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_sel | input | NUM_BUF | One-hot-or-more buffer select for the command |
| cmd_abort | input | 1 | Abort operation bit |
| cmd_ready | input | 1 | Mark-ready operation bit |
| cmd_empty | input | 1 | Mark-empty operation bit |
| prio_word | input | 4*NUM_BUF | Per-buffer priority nibbles, 3 low bits used |
| tx_req | output | 1 | Request to the transmit engine |
| tx_idx | output | IDX_W | Buffer being transmitted |
| tx_done | input | 1 | Transmit engine completion |
| state_word | output | 4*NUM_BUF | Packed buffer state nibbles |
| tx_busy | output | 1 | Transmitting status |
| idle | output | 1 | Idle status |
| txnf | output | 1 | At least one buffer is empty |
| frame_cnt | output | CNT_W | Count of sent frames |
| evt_txdone | output | 1 | Frame-sent event pulse |
| evt_bufchg | output | 1 | Buffer-state-change event pulse |

## Verification
A buffer left in a wrong state shows up in its status nibble at the very next clock edge after the command or completion. If that state is wrongly ready or wrongly not ready, the picker also shows it within one further edge as an unexpected or missing `tx_req`, or as a wrong `tx_idx`. A mistake in the comparison order only shows when two ready buffers share a priority, so ties, priority-0 buffers and a command aimed at the buffer in flight are driven on purpose. The frame counter and event pulses are checked at the cycle right after each completion.

// File: rtl/txs_pkg.sv
package txs_pkg;
   localparam int NIB_W = 4;

   typedef enum logic [NIB_W-1:0] {
      TB_EMPTY = 4'd0,
      TB_READY = 4'd1,
      TB_OK    = 4'd2,
      TB_FAIL  = 4'd3,
      TB_ABORT = 4'd4
   } tb_state_e;

   function automatic logic [NIB_W-1:0] nib_at(input logic [31:0] w, input int i);
      return w[i*NIB_W +: NIB_W];
   endfunction
endpackage

// File: rtl/txs_slot.sv
module txs_slot
   import txs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cmd_hit,
   input  logic      do_abort,
   input  logic      do_ready,
   input  logic      do_empty,
   input  logic      done_hit,
   output tb_state_e state_q
);
   tb_state_e state_d;

   always_comb begin
      state_d = state_q;
      if (cmd_hit) begin
         if (do_abort && state_d == TB_READY)
            state_d = TB_ABORT;
         if (do_ready && state_d != TB_READY)
            state_d = TB_READY;
         if (do_empty && (state_d == TB_OK || state_d == TB_FAIL || state_d == TB_ABORT))
            state_d = TB_EMPTY;
      end
      if (done_hit)
         state_d = TB_OK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= TB_EMPTY;
      else        state_q <= state_d;
   end

   // R3: a lone abort leaves a non-ready buffer alone
   p_abort_only_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hit && do_abort && !do_ready && !do_empty && !done_hit && state_q != TB_READY
      |=> $stable(state_q));

   // R5: mark-empty never clears a ready buffer
   p_empty_keeps_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hit && !do_abort && do_empty && !done_hit && state_q == TB_READY
      |=> state_q == TB_READY);
endmodule

// File: rtl/txs_pick.sv
module txs_pick
   import txs_pkg::*;
#(
   parameter int NUM_BUF = 4,
   parameter int PRIO_W  = 3,
   localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
)(
   input  logic [NUM_BUF-1:0]       ready_vec,
   input  logic [NIB_W*NUM_BUF-1:0] prio_word,
   output logic                     found,
   output logic [IDX_W-1:0]         idx
);
   logic [PRIO_W-1:0] best;

   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '0;
      for (int i = 0; i < NUM_BUF; i++) begin
         if (ready_vec[i] && prio_word[i*NIB_W +: PRIO_W] > best) begin
            best  = prio_word[i*NIB_W +: PRIO_W];
            idx   = IDX_W'(i);
            found = 1'b1;
         end
      end
   end

   // R8: a winner always carries a non-zero priority and is ready
   always_comb begin
      if (found) begin
         p_pick_nonzero_r8: assert (prio_word[idx*NIB_W +: PRIO_W] != '0 && ready_vec[idx]);
      end
   end
endmodule

// File: rtl/txbuf_sched.sv
module txbuf_sched
   import txs_pkg::*;
#(
   parameter int NUM_BUF = 4,
   parameter int PRIO_W  = 3,
   parameter int CNT_W   = 16,
   localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
   localparam int WORD_W = NIB_W * NUM_BUF
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_en,
   input  logic               cmd_valid,
   input  logic [NUM_BUF-1:0] cmd_sel,
   input  logic               cmd_abort,
   input  logic               cmd_ready,
   input  logic               cmd_empty,
   input  logic [WORD_W-1:0]  prio_word,
   output logic               tx_req,
   output logic [IDX_W-1:0]   tx_idx,
   input  logic               tx_done,
   output logic [WORD_W-1:0]  state_word,
   output logic               tx_busy,
   output logic               idle,
   output logic               txnf,
   output logic [CNT_W-1:0]   frame_cnt,
   output logic               evt_txdone,
   output logic               evt_bufchg
);
   generate
      if (NUM_BUF < 1 || NUM_BUF > 8) begin : g_bad_num
         $error("txbuf_sched: NUM_BUF must be 1..8");
      end
      if (PRIO_W < 1 || PRIO_W > NIB_W) begin : g_bad_prio
         $error("txbuf_sched: PRIO_W must be 1..4");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("txbuf_sched: CNT_W must be positive");
      end
   endgenerate

   logic               busy_q;
   logic [IDX_W-1:0]   idx_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               evt_q;
   logic               pick_found;
   logic [IDX_W-1:0]   pick_idx;
   logic               launch;
   logic               finish;
   logic               cmd_go;
   logic [NUM_BUF-1:0] ready_vec;
   logic [NUM_BUF-1:0] empty_vec;
   tb_state_e          st [NUM_BUF];

   assign cmd_go = cmd_valid && ctrl_en;
   assign launch = ctrl_en && !busy_q && pick_found;
   assign finish = busy_q && tx_done;

   for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
      logic guard;
      assign guard = (busy_q && idx_q == IDX_W'(g)) || (launch && pick_idx == IDX_W'(g));

      txs_slot u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmd_hit  (cmd_go && cmd_sel[g] && !guard),
         .do_abort (cmd_abort),
         .do_ready (cmd_ready),
         .do_empty (cmd_empty),
         .done_hit (finish && idx_q == IDX_W'(g)),
         .state_q  (st[g])
      );

      assign state_word[g*NIB_W +: NIB_W] = st[g];
      assign ready_vec[g] = (st[g] == TB_READY);
      assign empty_vec[g] = (st[g] == TB_EMPTY);
   end

   txs_pick #(.NUM_BUF(NUM_BUF), .PRIO_W(PRIO_W)) u_pick (
      .ready_vec (ready_vec),
      .prio_word (prio_word),
      .found     (pick_found),
      .idx       (pick_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         cnt_q  <= '0;
         evt_q  <= 1'b0;
      end else begin
         evt_q <= finish;
         if (finish) begin
            busy_q <= 1'b0;
            cnt_q  <= cnt_q + 1'b1;
         end else if (launch) begin
            busy_q <= 1'b1;
            idx_q  <= pick_idx;
         end
      end
   end

   assign tx_req     = busy_q;
   assign tx_idx     = idx_q;
   assign tx_busy    = busy_q;
   assign idle       = !busy_q;
   assign txnf       = |empty_vec;
   assign frame_cnt  = cnt_q;
   assign evt_txdone = evt_q;
   assign evt_bufchg = evt_q;

   // R9: a chosen buffer was ready when the request rose
   p_launch_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> nib_at(32'(state_word), int'(idx_q)) == TB_READY);

   // R9: request and index hold until completion
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !tx_done |=> busy_q && $stable(idx_q));

   // R10: the completed buffer reads transmitted-OK next cycle
   p_done_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> nib_at(32'(state_word), int'($past(idx_q))) == TB_OK);

   // R10: one count per completed frame
   p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> frame_cnt == $past(frame_cnt) + 1'b1);

   // R7: with the controller disabled no state moves
   p_disabled_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en && !finish |=> $stable(state_word));
endmodule

// File: tb/txbuf_sched_bench.sv
module txbuf_sched_bench;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_en = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [NB-1:0] cmd_sel = '0;
   logic          cmd_abort = 1'b0;
   logic          cmd_ready = 1'b0;
   logic          cmd_empty = 1'b0;
   logic [15:0]   prio_word = '0;
   logic          tx_req;
   logic [1:0]    tx_idx;
   logic          tx_done = 1'b0;
   logic [15:0]   state_word;
   logic          tx_busy, idle, txnf;
   logic [15:0]   frame_cnt;
   logic          evt_txdone, evt_bufchg;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   txbuf_sched #(.NUM_BUF(NB), .PRIO_W(3), .CNT_W(16)) u_txbuf_sched (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cmd_valid(cmd_valid),
      .cmd_sel(cmd_sel), .cmd_abort(cmd_abort), .cmd_ready(cmd_ready),
      .cmd_empty(cmd_empty), .prio_word(prio_word), .tx_req(tx_req),
      .tx_idx(tx_idx), .tx_done(tx_done), .state_word(state_word),
      .tx_busy(tx_busy), .idle(idle), .txnf(txnf), .frame_cnt(frame_cnt),
      .evt_txdone(evt_txdone), .evt_bufchg(evt_bufchg)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive one command from a negedge, release at the next negedge
   task automatic send_cmd(input logic [NB-1:0] sel, input logic a, input logic r, input logic e);
      cmd_valid = 1'b1; cmd_sel = sel; cmd_abort = a; cmd_ready = r; cmd_empty = e;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_sel = '0; cmd_abort = 1'b0; cmd_ready = 1'b0; cmd_empty = 1'b0;
   endtask

   task automatic pulse_done();
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 state_word", 32'(state_word), 32'h0000);
      chk("R1 idle/busy/req", {idle, tx_busy, tx_req}, 3'b100);
      chk("R1 txnf/cnt/evt", {txnf, frame_cnt, evt_txdone, evt_bufchg}, {1'b1, 16'd0, 2'b00});
   endtask

   task automatic t_disabled_cmd();
      send_cmd(4'b1111, 1'b0, 1'b1, 1'b0);
      chk("R7 disabled command ignored", 32'(state_word), 32'h0000);
   endtask

   task automatic t_basic_cmds();
      ctrl_en = 1'b1;
      send_cmd(4'b0101, 1'b0, 1'b1, 1'b0);
      chk("R2 R4 R7 ready on selected only", 32'(state_word), 32'h0101);
      chk("R8 prio 0 never sent", 32'(tx_req), 32'd0);
      chk("R12 txnf with empties", 32'(txnf), 32'd1);
      send_cmd(4'b0011, 1'b1, 1'b0, 1'b0);
      chk("R3 abort ready, empty untouched", 32'(state_word), 32'h0104);
      send_cmd(4'b0101, 1'b0, 1'b0, 1'b1);
      chk("R5 empty from aborted, ready kept", 32'(state_word), 32'h0100);
      send_cmd(4'b0100, 1'b1, 1'b0, 1'b1);
      chk("R6 abort then empty", 32'(state_word), 32'h0000);
      send_cmd(4'b1111, 1'b0, 1'b1, 1'b0);
      chk("R12 txnf clear when none empty", {16'(state_word), 15'd0, txnf}, {16'h1111, 16'd0});
   endtask

   task automatic t_drain();
      prio_word = 16'h0552;
      @(negedge clk);
      chk("R8 tie goes to lowest index", {tx_req, 30'(tx_idx)}, {1'b1, 30'd1});
      chk("R11 busy while sending", {tx_busy, idle}, 2'b10);
      send_cmd(4'b0010, 1'b1, 1'b0, 1'b0);
      chk("R9 command to in-flight buffer ignored", {16'(state_word), 15'd0, tx_req}, {16'h1111, 16'd1});
      pulse_done();
      chk("R10 first completion", {16'(state_word), frame_cnt}, {16'h1121, 16'd1});
      chk("R10 events and release", {evt_txdone, evt_bufchg, tx_req, idle}, 4'b1101);
      @(negedge clk);
      chk("R10 next pick, events drop", {tx_req, evt_txdone, evt_bufchg, 29'(tx_idx)}, {3'b100, 29'd2});
      pulse_done();
      chk("R10 second completion", {16'(state_word), frame_cnt}, {16'h1221, 16'd2});
      @(negedge clk);
      chk("R8 lower priority last", {tx_req, 31'(tx_idx)}, {1'b1, 31'd0});
      pulse_done();
      chk("R10 third completion", {16'(state_word), frame_cnt}, {16'h1222, 16'd3});
      @(negedge clk);
      chk("R8 prio 0 buffer left", 32'(tx_req), 32'd0);
      prio_word = 16'h0000;
   endtask

   task automatic t_ordering();
      send_cmd(4'b0001, 1'b0, 1'b1, 1'b1);
      chk("R6 ready then empty keeps ready", 32'(state_word), 32'h1221);
      send_cmd(4'b0010, 1'b0, 1'b1, 1'b0);
      chk("R4 ready from ok", 32'(state_word), 32'h1211);
   endtask

   task automatic t_enable_gate();
      ctrl_en = 1'b0;
      prio_word = 16'h7000;
      repeat (3) @(negedge clk);
      chk("R8 no start while disabled", {tx_req, 15'd0, 16'(state_word)}, {16'd0, 16'h1211});
      ctrl_en = 1'b1;
      @(negedge clk);
      chk("R8 start after enable", {tx_req, 31'(tx_idx)}, {1'b1, 31'd3});
      pulse_done();
      chk("R10 R12 final", {16'(state_word), 15'(frame_cnt), txnf}, {16'h2211, 15'd4, 1'b0});
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_disabled_cmd();
      t_basic_cmds();
      t_drain();
      t_ordering();
      t_enable_gate();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule